// File: doc/BRIEF.md
# Three-Lane Partial-Reuse FIR Filter

This block is a 3-tap FIR filter that works three samples at a time. Each accepted stream word carries three 8-bit unsigned pixels. Each emitted word carries the three filtered results for those pixels. A direct form would need nine multipliers for the nine tap products. This block forms only six products instead. Each of the six multiplies a sum of neighbouring pixels by a sum of neighbouring coefficients. Subtracting one product from another recovers the terms that are needed. Two products from each word are held in registers so the next word can complete its older outputs.

The three coefficients are live inputs and are read on the cycle a word is accepted. Words are grouped into frames of fixed length. The final output word of each frame is flagged as last. The carried history is cleared at the end of each frame, so every frame starts with zero history. The block sits between an upstream stream source and a downstream stream sink. It moves one word per clock whenever both sides allow it.

Top module: `tri_lane_fir`

## Requirements
- R1: Input lane k (bits [8k+7:8k], k = 0..2) holds sample x(n-k), with lane 0 the newest. Output lane k holds y(n-k) in the same bit positions. Output bits [31:24] are zero. Input bits [31:24] are ignored.
- R2: Output lane 0 equals (h0·x(n) + h1·x(n-1) + h2·x(n-2)) mod 256.
- R3: Output lane 1 equals (h0·x(n-1) + h1·x(n-2) + h2·x(n-3)) mod 256. Here x(n-3) is lane 0 of the previous word of the frame.
- R4: Output lane 2 equals (h0·x(n-2) + h1·x(n-3) + h2·x(n-4)) mod 256. Here x(n-3) and x(n-4) are lanes 0 and 1 of the previous word of the frame.
- R5: The first word after reset and the first word of each frame use zero for every term from an earlier word.
- R6: Coefficients are sampled when a word is accepted. Terms carried from the previous word keep the coefficients that were in force when that word was accepted.
- R7: The last flag is high on output word FRAME_LEN of each frame and low on every other output word. This pattern repeats frame after frame.
- R8: The result of an accepted word is valid on the clock edge after it is accepted. With the sink always ready, a new word is accepted every clock.
- R9: While an output word is valid and the sink is not ready, the output word and last flag hold steady and no input is accepted.
- R10: During and just after reset, the output is not valid and the input is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| kern0_i | input | 8 | Coefficient h0, applied to the newest sample |
| kern1_i | input | 8 | Coefficient h1 |
| kern2_i | input | 8 | Coefficient h2 |
| s_valid_i | input | 1 | Input word valid |
| s_ready_o | output | 1 | Block can take an input word |
| s_data_i | input | 32 | Three packed input pixels |
| m_valid_o | output | 1 | Output word valid |
| m_ready_i | input | 1 | Sink can take the output word |
| m_data_o | output | 32 | Three packed filtered pixels |
| m_last_o | output | 1 | Final word of a frame |

## Verification
The only register between input and output is the output stage. A word accepted at one rising edge therefore shows its three lanes and its last flag from that edge onward. The bench drives each word at a falling edge and checks that word's result at the next falling edge. When words stream back to back, each falling edge checks the previous word and drives the next one. For a stalled sink, the bench checks the held word at every falling edge. After the sink becomes ready, the pending input's result is checked one falling edge later, and the bench then confirms that no duplicate word follows.

// File: rtl/tri_lane_fir_pkg.sv
package tri_lane_fir_pkg;

   localparam int unsigned NUM_PART = 6;

   // slots of the partial-product vector
   localparam int unsigned IDX_XH2  = 0;  // x(n)*h2
   localparam int unsigned IDX_X2H0 = 1;  // x(n-2)*h0
   localparam int unsigned IDX_X1H1 = 2;  // x(n-1)*h1
   localparam int unsigned IDX_BSUM = 3;  // (x(n)+x(n-1))*(h1+h2)
   localparam int unsigned IDX_ASUM = 4;  // (x(n-1)+x(n-2))*(h0+h1)
   localparam int unsigned IDX_FULL = 5;  // (x(n)+x(n-1)+x(n-2))*(h0+h1+h2)

   // fld: 0 = first sample lane, 1 = last sample lane,
   //      2 = first coefficient, 3 = last coefficient
   function automatic int unsigned part_rng(input int unsigned idx,
                                            input int unsigned fld);
      logic [15:0] enc;
      case (idx)
         0:       enc = 16'h0022;
         1:       enc = 16'h2200;
         2:       enc = 16'h1111;
         3:       enc = 16'h0112;
         4:       enc = 16'h1201;
         default: enc = 16'h0202;
      endcase
      return 32'(enc[4*(3-fld) +: 4]);
   endfunction

endpackage

// File: rtl/tlf_partial.sv
module tlf_partial #(
   parameter int PIX_W = 8,
   parameter int LANES = 3,
   parameter int SUM_W = 10,
   parameter int XLO   = 0,
   parameter int XHI   = 0,
   parameter int HLO   = 0,
   parameter int HHI   = 0
) (
   input  logic [LANES*PIX_W-1:0] x_i,
   input  logic [LANES*PIX_W-1:0] h_i,
   output logic [2*SUM_W-1:0]     p_o
);
   localparam int PROD_W = 2 * SUM_W;

   logic [SUM_W-1:0] xs;
   logic [SUM_W-1:0] hs;

   always_comb begin
      xs = '0;
      hs = '0;
      for (int k = 0; k < LANES; k++) begin
         if (k >= XLO && k <= XHI) xs = xs + SUM_W'(x_i[k*PIX_W +: PIX_W]);
         if (k >= HLO && k <= HHI) hs = hs + SUM_W'(h_i[k*PIX_W +: PIX_W]);
      end
      p_o = PROD_W'(xs) * PROD_W'(hs);
   end
endmodule

// File: rtl/tlf_rebuild.sv
module tlf_rebuild
   import tri_lane_fir_pkg::*;
#(
   parameter int PROD_W = 20,
   parameter int ACC_W  = 22
) (
   input  logic [NUM_PART-1:0][PROD_W-1:0] part_i,
   input  logic [ACC_W-1:0]                prev_xh2_i,
   input  logic [ACC_W-1:0]                prev_b_i,
   output logic [2:0][ACC_W-1:0]           y_o,
   output logic [ACC_W-1:0]                next_xh2_o,
   output logic [ACC_W-1:0]                next_b_o
);
   logic [ACC_W-1:0] xh2, x2h0, x1h1, a_sum, b_sum;

   always_comb begin
      xh2   = ACC_W'(part_i[IDX_XH2]);
      x2h0  = ACC_W'(part_i[IDX_X2H0]);
      x1h1  = ACC_W'(part_i[IDX_X1H1]);
      // x(n-1)h0 + x(n-2)h1
      a_sum = ACC_W'(part_i[IDX_ASUM]) - x1h1 - x2h0;
      // x(n)h1 + x(n-1)h2
      b_sum = ACC_W'(part_i[IDX_BSUM]) - x1h1 - xh2;
      y_o[0] = ACC_W'(part_i[IDX_FULL]) - a_sum - b_sum - xh2 - x2h0;
      y_o[1] = a_sum + prev_xh2_i;
      y_o[2] = x2h0 + prev_b_i;
      next_xh2_o = xh2;
      next_b_o   = b_sum;
   end
endmodule

// File: rtl/tlf_frame_ctr.sv
module tlf_frame_ctr #(
   parameter int FRAME_LEN = 214,
   parameter int CNT_W     = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic adv_i,
   output logic last_o
);
   logic [CNT_W-1:0] cnt;

   assign last_o = (cnt == CNT_W'(FRAME_LEN - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt <= '0;
      else if (adv_i)  cnt <= last_o ? '0 : cnt + 1'b1;
   end
endmodule

// File: rtl/tri_lane_fir.sv
module tri_lane_fir
   import tri_lane_fir_pkg::*;
#(
   parameter int PIX_W     = 8,
   parameter int LANES     = 3,
   parameter int WORD_W    = 32,
   parameter int FRAME_LEN = 214
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PIX_W-1:0]  kern0_i,
   input  logic [PIX_W-1:0]  kern1_i,
   input  logic [PIX_W-1:0]  kern2_i,
   input  logic              s_valid_i,
   output logic              s_ready_o,
   input  logic [WORD_W-1:0] s_data_i,
   output logic              m_valid_o,
   input  logic              m_ready_i,
   output logic [WORD_W-1:0] m_data_o,
   output logic              m_last_o
);
   localparam int LANE_BITS = LANES * PIX_W;
   localparam int PAD_W     = WORD_W - LANE_BITS;
   localparam int SUM_W     = PIX_W + $clog2(LANES + 1);
   localparam int PROD_W    = 2 * SUM_W;
   localparam int ACC_W     = PROD_W + 2;
   localparam int CNT_W     = $clog2(FRAME_LEN);

   // elaboration checks
   if (LANES != 3) begin : g_bad_lanes
      $error("tri_lane_fir: the partial set is built for three lanes");
   end
   if (WORD_W < LANE_BITS) begin : g_bad_word
      $error("tri_lane_fir: word too narrow for the lanes");
   end
   if (FRAME_LEN < 2) begin : g_bad_frame
      $error("tri_lane_fir: frame must hold at least two words");
   end

   logic [LANE_BITS-1:0]               x_lanes, h_lanes;
   logic [NUM_PART-1:0][PROD_W-1:0]    parts;
   logic [2:0][ACC_W-1:0]              y_full;
   logic [ACC_W-1:0]                   st_xh2, st_b, nx_xh2, nx_b;
   logic [WORD_W-1:0]                  packed_y;
   logic                               take, frame_end;

   assign x_lanes   = s_data_i[LANE_BITS-1:0];
   assign h_lanes   = {kern2_i, kern1_i, kern0_i};
   assign s_ready_o = !m_valid_o || m_ready_i;
   assign take      = s_valid_i && s_ready_o;

   for (genvar g = 0; g < NUM_PART; g++) begin : g_part
      tlf_partial #(
         .PIX_W (PIX_W),
         .LANES (LANES),
         .SUM_W (SUM_W),
         .XLO   (int'(part_rng(g, 0))),
         .XHI   (int'(part_rng(g, 1))),
         .HLO   (int'(part_rng(g, 2))),
         .HHI   (int'(part_rng(g, 3)))
      ) u_part (
         .x_i (x_lanes),
         .h_i (h_lanes),
         .p_o (parts[g])
      );
   end

   tlf_rebuild #(.PROD_W(PROD_W), .ACC_W(ACC_W)) u_rebuild (
      .part_i     (parts),
      .prev_xh2_i (st_xh2),
      .prev_b_i   (st_b),
      .y_o        (y_full),
      .next_xh2_o (nx_xh2),
      .next_b_o   (nx_b)
   );

   tlf_frame_ctr #(.FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) u_frame (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv_i  (take),
      .last_o (frame_end)
   );

   for (genvar k = 0; k < LANES; k++) begin : g_pack
      assign packed_y[k*PIX_W +: PIX_W] = y_full[k][PIX_W-1:0];
   end
   if (PAD_W > 0) begin : g_pad
      logic unused_pad;
      assign packed_y[WORD_W-1:LANE_BITS] = '0;
      assign unused_pad = ^s_data_i[WORD_W-1:LANE_BITS];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         m_valid_o <= 1'b0;
         m_data_o  <= '0;
         m_last_o  <= 1'b0;
         st_xh2    <= '0;
         st_b      <= '0;
      end else if (take) begin
         m_valid_o <= 1'b1;
         m_data_o  <= packed_y;
         m_last_o  <= frame_end;
         st_xh2    <= frame_end ? '0 : nx_xh2;
         st_b      <= frame_end ? '0 : nx_b;
      end else if (m_ready_i) begin
         m_valid_o <= 1'b0;
      end
   end
endmodule

// File: rtl/tri_lane_fir_chk.sv
module tri_lane_fir_chk #(
   parameter int WORD_W    = 32,
   parameter int FRAME_LEN = 214
) (
   input logic              clk,
   input logic              rst_n,
   input logic              s_valid,
   input logic              s_ready,
   input logic              m_valid,
   input logic              m_ready,
   input logic [WORD_W-1:0] m_data,
   input logic              m_last
);
   localparam int OC_W = $clog2(FRAME_LEN) + 1;

   logic [OC_W-1:0] out_cnt;
   logic            out_fire;

   assign out_fire = m_valid && m_ready;

   always_ff @(posedge clk) begin
      if (!rst_n)        out_cnt <= '0;
      else if (out_fire) out_cnt <= (out_cnt == OC_W'(FRAME_LEN - 1)) ? '0 : out_cnt + 1'b1;
   end

   // R9
   hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_last));

   // R9
   no_take_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid && !m_ready |-> !s_ready);

   // R8
   accept_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s_valid && s_ready |=> m_valid);

   // R7
   last_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_fire && m_last |-> out_cnt == OC_W'(FRAME_LEN - 1));

   // R7
   last_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_fire && out_cnt == OC_W'(FRAME_LEN - 1) |-> m_last);
endmodule

bind tri_lane_fir tri_lane_fir_chk #(.WORD_W(WORD_W), .FRAME_LEN(FRAME_LEN)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .s_valid (s_valid_i),
   .s_ready (s_ready_o),
   .m_valid (m_valid_o),
   .m_ready (m_ready_i),
   .m_data  (m_data_o),
   .m_last  (m_last_o)
);

// File: tb/tri_lane_fir_bench.sv
module tri_lane_fir_bench;
   localparam int FRAME = 8;
   localparam int NV    = 10;
   // {x2,x1,x0 , h2,h1,h0}
   localparam logic [47:0] VEC [NV] = '{
      48'h030201_000001, 48'h060504_030201, 48'h0A1400_020101,
      48'hFFFFFF_FFFFFF, 48'h000000_FFFFFF, 48'h7F80FF_010203,
      48'h112233_100804, 48'h010101_000100, 48'hC0FFEE_0A0B0C,
      48'h123456_050607
   };

   logic        clk = 0;
   logic        rst_n = 0;
   logic [7:0]  k0 = 0, k1 = 0, k2 = 0;
   logic        s_valid = 0, s_ready, m_valid, m_ready = 1, m_last;
   logic [31:0] s_data = 0, m_data;

   int total = 0, bad = 0;
   bit done = 0;
   int st_xh2 = 0, st_b = 0, fcnt = 0;
   logic [31:0] ey;
   logic        el;

   always #10 clk = ~clk;

   tri_lane_fir #(.FRAME_LEN(FRAME)) u_tri_lane_fir (
      .clk(clk), .rst_n(rst_n), .kern0_i(k0), .kern1_i(k1), .kern2_i(k2),
      .s_valid_i(s_valid), .s_ready_o(s_ready), .s_data_i(s_data),
      .m_valid_o(m_valid), .m_ready_i(m_ready), .m_data_o(m_data), .m_last_o(m_last)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_word(input logic [31:0] e, input logic l);
      check("R2 lane0", 32'(m_data[7:0]),   32'(e[7:0]));
      check("R3 lane1", 32'(m_data[15:8]),  32'(e[15:8]));
      check("R4 lane2", 32'(m_data[23:16]), 32'(e[23:16]));
      check("R1 pad",   32'(m_data[31:24]), 32'h0);
      check("R7 last",  32'(m_last),        32'(l));
      check("R8 valid", 32'(m_valid),       32'h1);
   endtask

   task automatic model(input logic [23:0] px, input logic [23:0] hh);
      int a0, a1, a2, h0, h1, h2, y0, y1, y2;
      a0 = px[7:0]; a1 = px[15:8]; a2 = px[23:16];
      h0 = hh[7:0]; h1 = hh[15:8]; h2 = hh[23:16];
      y0 = h0*a0 + h1*a1 + h2*a2;
      y1 = h0*a1 + h1*a2 + st_xh2;
      y2 = h0*a2 + st_b;
      ey = {8'h00, 8'(y2), 8'(y1), 8'(y0)};
      el = (fcnt == FRAME - 1);
      st_xh2 = h2*a0;
      st_b   = h1*a0 + h2*a1;
      if (el) begin st_xh2 = 0; st_b = 0; fcnt = 0; end
      else fcnt++;
   endtask

   task automatic drive(input logic [23:0] px, input logic [23:0] hh, input logic [7:0] junk);
      s_valid = 1;
      s_data  = {junk, px};
      {k2, k1, k0} = hh;
   endtask

   task automatic send_one(input logic [23:0] px, input logic [23:0] hh);
      @(negedge clk);
      drive(px, hh, 8'hA5);
      model(px, hh);
      @(negedge clk);
      check_word(ey, el);
      s_valid = 0;
   endtask

   initial begin
      logic [31:0] pend_e, e1;
      logic        pend_l, pend, l1;
      // R10 reset state
      repeat (3) @(negedge clk);
      check("R10 valid in reset", 32'(m_valid), 32'h0);
      rst_n = 1;
      @(negedge clk);
      check("R10 valid after reset", 32'(m_valid), 32'h0);
      check("R10 ready after reset", 32'(s_ready), 32'h1);

      // table walk, back to back (R5 R6 R7 R8): crosses the frame boundary
      pend = 0;
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         if (pend) check_word(pend_e, pend_l);
         check("R8 ready streaming", 32'(s_ready), 32'h1);
         drive(VEC[i][47:24], VEC[i][23:0], 8'(i * 37 + 1));
         model(VEC[i][47:24], VEC[i][23:0]);
         pend_e = ey; pend_l = el; pend = 1;
      end
      @(negedge clk);
      check_word(pend_e, pend_l);
      s_valid = 0;
      @(negedge clk);
      check("R8 idle after stream", 32'(m_valid), 32'h0);

      // R9 back-pressure
      m_ready = 0;
      drive(24'h102030, 24'h030201, 8'hFF);
      model(24'h102030, 24'h030201);
      e1 = ey; l1 = el;
      @(negedge clk);
      check_word(e1, l1);
      check("R9 ready low when stalled", 32'(s_ready), 32'h0);
      drive(24'h0F0E0D, 24'h030201, 8'h00);
      @(negedge clk);
      check_word(e1, l1);
      check("R9 ready low when stalled", 32'(s_ready), 32'h0);
      m_ready = 1;
      model(24'h0F0E0D, 24'h030201);
      @(negedge clk);
      check_word(ey, el);
      s_valid = 0;
      @(negedge clk);
      check("R9 no duplicate", 32'(m_valid), 32'h0);

      // complete the second frame: last on word FRAME (R7), then new frame (R5)
      for (int j = 0; j < 5; j++)
         send_one(24'(32'h050403 + j * 32'h010101), 24'h020304);

      // mid-frame reset (R5 R10)
      send_one(24'h090909, 24'h090909);
      @(negedge clk);
      rst_n = 0;
      @(negedge clk);
      @(negedge clk);
      check("R10 valid cleared by reset", 32'(m_valid), 32'h0);
      rst_n = 1;
      st_xh2 = 0; st_b = 0; fcnt = 0;
      send_one(24'h010203, 24'h040506);
      send_one(24'hFF00FF, 24'hFFFFFF);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog run did not end");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule